// File: doc/BRIEF.md
# Stacked-Carrier Sinusoidal PWM Gate Generator

This block drives the twelve switch gates of a three-phase inverter whose legs each produce four voltage levels. One shared up/down counter forms a triangle, and fixed vertical offsets stack three copies of it into contiguous bands. All three copies share the same frequency, phase and peak. Three sinusoidal references, spaced a third of a turn apart, come from a phase accumulator and a quarter-wave table. A programmable gain scales them. Each reference is mapped into the carrier range and compared with every band. The comparison results, qualified by the sign of the reference, give four gates per leg.

The carrier half-period, the frequency tuning word and the amplitude gain are free-running inputs. A new half-period is taken at the counter's lowest point. Tuning and gain are taken at its highest point, so a reference never changes scale or speed part-way up a ramp. Every comparison and every gate is registered.

Top module: `mlpwm_gate_gen`

## Requirements
- R1: The counter runs 0,1,…,P,P-1,…,1 and repeats, a period of 2P clocks, where P is the latched half-period. The carriers are bottom = t, middle = t+P, top = t+2P, with t the counter value.
- R2: `period_i` is latched only when the counter turns at zero. After reset the first clock latches it.
- R3: The accumulator adds the latched tuning word every clock. Phase A reads the accumulator as is, phase B adds 0xAAAAAAAB and phase C adds 0x55555555. The top two phase bits select the quadrant and the next 6 bits give index i. Quadrants 1 and 3 read entry 64-i, and quadrants 2 and 3 negate the result. Entry n equals floor(32767*16*u/(5*16384-4*u)), with u = n*(128-n).
- R4: reference = floor(sample*g/32768), where g is the latched gain. Any `amp_i` above 32768 counts as 32768.
- R5: The level of a reference r is L = floor((r+32768)*3P/65536). A reference is positive when r>0 and negative when r<0.
- R6: The top main gate is high when L is above the top carrier.
- R7: The upper auxiliary gate is high when L is below the top carrier, L is above the middle carrier and the reference is positive.
- R8: The lower auxiliary gate is high in two cases: L is above the bottom carrier with a negative reference, or L is below the middle carrier with a positive reference.
- R9: The bottom main gate is high when L is below the bottom carrier.
- R10: `gate_o[4*p+k]` belongs to phase p (0=A, 1=B, 2=C). Within a phase, k=0 is the top main gate, k=1 the upper auxiliary, k=2 the lower auxiliary and k=3 the bottom main.
- R11: Tuning word and gain are latched only on the clock where the counter sits at P while rising. Both reset to zero, so all gates stay low until the first such point has passed.
- R12: Asserting reset forces all gates low at once. Every gate changes only on a clock edge.
- R13: Within a leg, the two main gates are never high together, and the two auxiliary gates are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_word_i | input | 32 | Phase increment per clock |
| amp_i | input | 16 | Reference gain, 32768 = unity |
| period_i | input | 12 | Carrier half-period in clocks |
| gate_o | output | 12 | Gate outputs, grouped per leg |

## Verification
A gate reflects the counter and accumulator values it was computed from three clocks later. A new gain or tuning word only takes effect after the next rising-counter peak, and a new half-period after the next counter zero. The bench therefore waits well beyond two carrier periods after any input change. It then counts how many clocks each gate is high over exactly 2P consecutive clocks. Any such window covers one full carrier cycle whatever its alignment, so these counts can be compared with totals worked out from R1 to R10, with no cycle-exact alignment needed. The deferral check starts counting right after reset, in the clocks before the first peak can occur. The asynchronous reset check samples 1 ns after reset falls.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int NUM_PH = 3;
  localparam int NUM_CAR = 3;
  localparam int GATES_PER_LEG = 4;

  typedef enum logic [1:0] {
    G_TOP_MAIN = 2'd0,
    G_UP_AUX   = 2'd1,
    G_LO_AUX   = 2'd2,
    G_BOT_MAIN = 2'd3
  } gate_idx_e;

  // quarter-wave entry, rational sine approximation over a half wave of 2*qn steps
  function automatic logic [31:0] qtab_val(input int idx, input int qn, input int fs);
    longint u, d;
    u = longint'(idx) * longint'(2 * qn - idx);
    d = longint'(2 * qn) * longint'(2 * qn);
    return 32'((longint'(fs) * 16 * u) / (5 * d - 4 * u));
  endfunction

  // offset of k thirds of a turn, rounded
  function automatic longint phase_off(input int k, input int aw);
    return ((longint'(1) <<< aw) * longint'(k) + 1) / 3;
  endfunction
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int PER_W = 12,
  localparam int CAR_W = PER_W + 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [PER_W-1:0]              period_i,
  output logic                          peak_o,
  output logic [CAR_W-1:0]              per_o,
  output logic [mlpwm_pkg::NUM_CAR-1:0][CAR_W-1:0] car_o
);
  logic [PER_W-1:0] cnt_q, per_q;
  logic             up_q;
  logic             at_top, at_bot;

  assign at_top = up_q && (cnt_q == per_q);
  assign at_bot = !up_q && (cnt_q == '0);
  assign peak_o = at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      up_q  <= 1'b0;
    end else if (at_bot) begin
      per_q <= period_i;
      up_q  <= 1'b1;
      cnt_q <= (period_i == '0) ? '0 : PER_W'(1);
    end else if (at_top) begin
      up_q  <= 1'b0;
      cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // one register stage to line up with the reference pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) per_o <= '0;
    else         per_o <= CAR_W'(per_q);
  end

  for (genvar k = 0; k < mlpwm_pkg::NUM_CAR; k++) begin : g_band
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) car_o[k] <= '0;
      else         car_o[k] <= CAR_W'(cnt_q) + CAR_W'(k) * CAR_W'(per_q);
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_q);

  p_per_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_bot |=> $stable(per_q));
endmodule

// File: rtl/mlpwm_ref.sv
module mlpwm_ref #(
  parameter int ACC_W  = 32,
  parameter int REF_W  = 16,
  parameter int AMP_W  = 16,
  parameter int LUT_AW = 6,
  localparam int QN    = 2 ** LUT_AW,
  localparam int UNITY = 2 ** (REF_W - 1),
  localparam int FS    = UNITY - 1,
  localparam int PRD_W = REF_W + AMP_W + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         peak_i,
  input  logic [ACC_W-1:0]             tune_i,
  input  logic [AMP_W-1:0]             amp_i,
  output logic [mlpwm_pkg::NUM_PH-1:0][REF_W-1:0] ref_o
);
  logic [ACC_W-1:0] acc_q, ftw_q;
  logic [AMP_W-1:0] amp_q, amp_sat;
  logic [REF_W-1:0] qtab [QN+1];

  for (genvar i = 0; i <= QN; i++) begin : g_tab
    localparam logic [REF_W-1:0] ENTRY = REF_W'(mlpwm_pkg::qtab_val(i, QN, FS));
    assign qtab[i] = ENTRY;
  end

  assign amp_sat = (amp_i > AMP_W'(UNITY)) ? AMP_W'(UNITY) : amp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_q <= '0;
      amp_q <= '0;
    end else if (peak_i) begin
      ftw_q <= tune_i;
      amp_q <= amp_sat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + ftw_q;
  end

  for (genvar p = 0; p < mlpwm_pkg::NUM_PH; p++) begin : g_ph
    // phase B lags A by a third of a turn, phase C by two thirds
    localparam logic [ACC_W-1:0] OFF = ACC_W'(mlpwm_pkg::phase_off((3 - p) % 3, ACC_W));
    logic [LUT_AW+1:0]       top_bits;
    logic [LUT_AW:0]         addr;
    logic signed [REF_W-1:0] mag, smp;
    logic signed [PRD_W-1:0] prod;

    assign top_bits = (LUT_AW + 2)'((acc_q + OFF) >> (ACC_W - LUT_AW - 2));
    assign addr = top_bits[LUT_AW] ? (LUT_AW + 1)'(QN) - {1'b0, top_bits[LUT_AW-1:0]}
                                   : {1'b0, top_bits[LUT_AW-1:0]};
    assign mag  = $signed(qtab[addr]);
    assign smp  = top_bits[LUT_AW+1] ? -mag : mag;
    assign prod = PRD_W'(smp) * $signed({1'b0, amp_q});

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ref_o[p] <= '0;
      else         ref_o[p] <= REF_W'(prod >>> (REF_W - 1));
    end
  end

  p_param_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak_i |=> ($stable(amp_q) && $stable(ftw_q)));

  p_gain_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_q <= AMP_W'(UNITY));
endmodule

// File: rtl/mlpwm_leg.sv
module mlpwm_leg #(
  parameter int REF_W = 16,
  parameter int CAR_W = 14,
  localparam int PRD_W = REF_W + CAR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [REF_W-1:0]              ref_i,
  input  logic [CAR_W-1:0]              per_i,
  input  logic [mlpwm_pkg::NUM_CAR-1:0][CAR_W-1:0] car_i,
  output logic [mlpwm_pkg::GATES_PER_LEG-1:0] gate_o
);
  import mlpwm_pkg::*;

  logic [REF_W-1:0] ref_u;
  logic [CAR_W-1:0] per3, lvl;
  logic [PRD_W-1:0] prod;
  logic             pos, neg;

  typedef struct packed {
    logic gt_top, lt_top, gt_mid, lt_mid, gt_bot, lt_bot, pos, neg;
  } cmp_t;
  cmp_t cmp_q;

  // offset binary: -32767..32767 maps onto 1..65535
  assign ref_u = {~ref_i[REF_W-1], ref_i[REF_W-2:0]};
  assign per3  = per_i + (per_i << 1);
  assign prod  = PRD_W'(ref_u) * PRD_W'(per3);
  assign lvl   = CAR_W'(prod >> REF_W);
  assign neg   = ref_i[REF_W-1];
  assign pos   = !ref_i[REF_W-1] && (ref_i[REF_W-2:0] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else begin
      cmp_q.gt_top <= lvl > car_i[2];
      cmp_q.lt_top <= lvl < car_i[2];
      cmp_q.gt_mid <= lvl > car_i[1];
      cmp_q.lt_mid <= lvl < car_i[1];
      cmp_q.gt_bot <= lvl > car_i[0];
      cmp_q.lt_bot <= lvl < car_i[0];
      cmp_q.pos    <= pos;
      cmp_q.neg    <= neg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o <= '0;
    end else begin
      gate_o[G_TOP_MAIN] <= cmp_q.gt_top;
      gate_o[G_UP_AUX]   <= cmp_q.lt_top && cmp_q.gt_mid && cmp_q.pos;
      gate_o[G_LO_AUX]   <= (cmp_q.gt_bot && cmp_q.neg) || (cmp_q.lt_mid && cmp_q.pos);
      gate_o[G_BOT_MAIN] <= cmp_q.lt_bot;
    end
  end

  p_main_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[G_TOP_MAIN] && gate_o[G_BOT_MAIN]));

  p_aux_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[G_UP_AUX] && gate_o[G_LO_AUX]));

  p_up_aux_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o[G_UP_AUX] |-> ($signed($past(ref_i, 2)) > 0));
endmodule

// File: rtl/mlpwm_gate_gen.sv
module mlpwm_gate_gen #(
  parameter int PER_W  = 12,
  parameter int ACC_W  = 32,
  parameter int REF_W  = 16,
  parameter int AMP_W  = 16,
  parameter int LUT_AW = 6,
  localparam int CAR_W = PER_W + 2,
  localparam int NG    = mlpwm_pkg::NUM_PH * mlpwm_pkg::GATES_PER_LEG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] tune_word_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [PER_W-1:0] period_i,
  output logic [NG-1:0]    gate_o
);
  import mlpwm_pkg::*;

  logic                             peak;
  logic [CAR_W-1:0]                 per_d;
  logic [NUM_CAR-1:0][CAR_W-1:0]    car_d;
  logic [NUM_PH-1:0][REF_W-1:0]     ref_d;

  mlpwm_carrier #(.PER_W(PER_W)) i_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .peak_o   (peak),
    .per_o    (per_d),
    .car_o    (car_d)
  );

  mlpwm_ref #(
    .ACC_W (ACC_W),
    .REF_W (REF_W),
    .AMP_W (AMP_W),
    .LUT_AW(LUT_AW)
  ) i_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .peak_i (peak),
    .tune_i (tune_word_i),
    .amp_i  (amp_i),
    .ref_o  (ref_d)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
    mlpwm_leg #(.REF_W(REF_W), .CAR_W(CAR_W)) i_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (ref_d[p]),
      .per_i  (per_d),
      .car_i  (car_d),
      .gate_o (gate_o[GATES_PER_LEG*p +: GATES_PER_LEG])
    );
  end
endmodule

// File: tb/test_mlpwm_gate_gen.sv
`timescale 1ns/1ps
module test_mlpwm_gate_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] tune = '0;
  logic [15:0] amp = '0;
  logic [11:0] per = '0;
  logic [11:0] gate;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mlpwm_gate_gen i_mlpwm_gate_gen (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tune_word_i (tune),
    .amp_i       (amp),
    .period_i    (per),
    .gate_o      (gate)
  );

  localparam int NV = 7;
  localparam int TV_PER [NV] = '{100, 100, 60, 37, 250, 9, 100};
  localparam int TV_AMP [NV] = '{0, 32768, 16384, 32768, 8000, 32768, 50000};

  function automatic int qtab(input int n);
    longint u;
    u = longint'(n) * longint'(128 - n);
    return int'((longint'(32767) * 16 * u) / (5 * 16384 - 4 * u));
  endfunction

  // tuning word zero: accumulator stays 0, so the R3 samples are fixed per phase
  function automatic int ref_of(input int leg, input int a);
    int s;
    longint pr;
    int g;
    g = (a > 32768) ? 32768 : a;
    case (leg)
      0:       s = 0;
      1:       s = -qtab(42);
      default: s = qtab(43);
    endcase
    pr = longint'(s) * longint'(g);
    return int'(pr >>> 15);
  endfunction

  function automatic int exp_cnt(input int leg, input int k, input int p, input int a);
    int r, l, n;
    r = ref_of(leg, a);
    l = int'((longint'(r + 32768) * 3 * p) >> 16);
    n = 0;
    for (int j = 0; j < 2 * p; j++) begin
      int t;
      bit g;
      t = (j <= p) ? j : 2 * p - j;
      case (k)
        0:       g = l > 2 * p + t;
        1:       g = (l < 2 * p + t) && (l > p + t) && (r > 0);
        2:       g = ((l > t) && (r < 0)) || ((l < p + t) && (r > 0));
        default: g = l < t;
      endcase
      n += int'(g);
    end
    return n;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int p, output int cnt [12]);
    for (int b = 0; b < 12; b++) cnt[b] = 0;
    repeat (2 * p) begin
      @(negedge clk);
      for (int b = 0; b < 12; b++) cnt[b] += int'(gate[b]);
    end
  endtask

  initial begin
    int cnt [12];
    int nz;
    int ovl;
    logic [11:0] seen;

    // R12: reset holds all gates low
    tune = 32'd0; amp = 16'd32768; per = 12'd200;
    settle(5);
    check("R12 gates during reset", int'(gate), 0);

    // R11: gain latched only at first counter peak (about 200 clocks in)
    rst_ni = 1'b1;
    nz = 0;
    repeat (150) begin
      @(negedge clk);
      if (gate != '0) nz++;
    end
    check("R11 gates low before first peak", nz, 0);
    settle(1200);
    measure(200, cnt);
    check("R11 leg B bottom main after peak", cnt[7], exp_cnt(1, 3, 200, 32768));
    check("R11 leg B lower aux after peak", cnt[6], exp_cnt(1, 2, 200, 32768));

    // vector table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 duty totals over one carrier cycle
    for (int v = 0; v < NV; v++) begin
      per = 12'(TV_PER[v]);
      amp = 16'(TV_AMP[v]);
      settle(1200);
      measure(TV_PER[v], cnt);
      for (int leg = 0; leg < 3; leg++) begin
        check($sformatf("R6 R10 v%0d leg%0d top main", v, leg),
              cnt[4*leg+0], exp_cnt(leg, 0, TV_PER[v], TV_AMP[v]));
        check($sformatf("R7 R10 v%0d leg%0d upper aux", v, leg),
              cnt[4*leg+1], exp_cnt(leg, 1, TV_PER[v], TV_AMP[v]));
        check($sformatf("R8 R5 v%0d leg%0d lower aux", v, leg),
              cnt[4*leg+2], exp_cnt(leg, 2, TV_PER[v], TV_AMP[v]));
        check($sformatf("R9 R1 R2 R3 R4 v%0d leg%0d bottom main", v, leg),
              cnt[4*leg+3], exp_cnt(leg, 3, TV_PER[v], TV_AMP[v]));
      end
    end

    // R12: asynchronous reset mid-run, gates are active here
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R12 gates cleared by async reset", int'(gate), 0);
    settle(3);
    rst_ni = 1'b1;

    // R13 and R3 with a rotating reference: no overlap, every gate used
    per = 12'd20; amp = 16'd32768; tune = 32'd2147484;
    settle(1200);
    ovl = 0;
    seen = '0;
    repeat (4000) begin
      @(negedge clk);
      seen |= gate;
      for (int leg = 0; leg < 3; leg++) begin
        if (gate[4*leg] && gate[4*leg+3]) ovl++;
        if (gate[4*leg+1] && gate[4*leg+2]) ovl++;
      end
    end
    check("R13 no main or aux overlap", ovl, 0);
    check("R3 all twelve gates active over a reference cycle", int'(seen), 12'hFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule